// File: doc/BRIEF.md
# Memory Error Report and Interrupt Controller

This block sits beside the error-correction logic of two memories, a RAM and a flash array. Each memory reports two kinds of error event as single-cycle pulses: a single-bit error that was corrected, and a multi-bit error that could not be corrected. Each pulse comes with the access address, the access attributes and the data word. The RAM also supplies the syndrome. A configuration register holds one enable bit for each of the four event categories. An enabled event replaces the contents of a status register with a single flag that names it. The same event also loads a set of capture registers for its memory. The block drives its interrupt requests from the status flags, masked by the enables.

Software uses a single-cycle register port to reach the block. Through it, software sets the enables, reads the status and the captured fault details, and clears flags by writing ones. The flash single-bit enable is protected by an external strap input. It can be turned on only while the strap is high.

Top module: `ecc_err_report`

## Requirements
- R1: After reset, the configuration, status and all capture registers read zero, and every interrupt output is low.
- R2: The configuration register (address 0) holds four enables: bit 0 RAM single-bit, bit 1 flash single-bit, bit 2 RAM non-correctable, bit 3 flash non-correctable. Writes load them and reads return them, with the other bits reading zero.
- R3: Configuration bit 1 can change from 0 to 1 only while `cfg_unlock` is high. Without the strap, a write of 1 leaves the bit as it was, and a write of 0 always clears it.
- R4: An event whose category enable is 0 sets no status flag and loads no capture register.
- R5: The status register (address 1) uses bit 0 for RAM single-bit, bit 1 for flash single-bit, bit 2 for RAM non-correctable and bit 3 for flash non-correctable, and bits 7:4 read zero. An enabled event leaves exactly its own flag set, one cycle after the pulse.
- R6: When several enabled events arrive in the same cycle, only one is recorded. Non-correctable beats single-bit, and at equal severity RAM beats flash. Only the recorded event loads a capture register.
- R7: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. An enabled event in the same cycle as a clear write takes precedence.
- R8: `irq_single` = (cfg bit 0 AND status bit 0) OR (cfg bit 1 AND status bit 1). Clearing an enable masks the request while the flag stays set.
- R9: `irq_ram_nc` = cfg bit 2 AND status bit 2, and `irq_flash_nc` = cfg bit 3 AND status bit 3. `irq_noncorr` is their OR, and `irq_any` = `irq_single` OR `irq_noncorr`.
- R10: A recorded flash event of either severity loads flash address (reg 2), attribute (reg 3) and data (reg 4).
- R11: A recorded RAM non-correctable event loads RAM address (reg 5), syndrome (reg 6), attribute (reg 7) and data (reg 8). A RAM single-bit event loads none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_unlock | input | 1 | Strap that allows flash single-bit enable to be set |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ram_sb_evt | input | 1 | RAM corrected single-bit event pulse |
| ram_nc_evt | input | 1 | RAM non-correctable event pulse |
| ram_addr | input | ADDR_W | RAM fault address |
| ram_attr | input | ATTR_W | RAM access attributes |
| ram_data | input | DATA_W | RAM data word |
| ram_syn | input | SYN_W | RAM syndrome |
| flash_sb_evt | input | 1 | Flash corrected single-bit event pulse |
| flash_nc_evt | input | 1 | Flash non-correctable event pulse |
| flash_addr | input | ADDR_W | Flash fault address |
| flash_attr | input | ATTR_W | Flash access attributes |
| flash_data | input | DATA_W | Flash data word |
| irq_single | output | 1 | Single-bit correction request |
| irq_ram_nc | output | 1 | RAM non-correctable request |
| irq_flash_nc | output | 1 | Flash non-correctable request |
| irq_noncorr | output | 1 | Any non-correctable request |
| irq_any | output | 1 | Combined request |

## Verification
Several properties are checked by assertions on every cycle. The status flags are never more than one-hot. An event with no enabled category never raises a flag. The flash single-bit enable never rises while the strap is low. A RAM non-correctable event always wins the next status value. The flash capture registers hold their values when no flash event is present. Other behaviours can only be shown by the bench's scenarios. These are the exact enable and status bit positions, the values captured in the fault registers, the priority outcome of each event mix, a clear write colliding with an event, and the masking of a set flag by a cleared enable.

// File: rtl/ecc_err_report.sv
module ecc_err_report #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_unlock,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ram_sb_evt,
  input  logic              ram_nc_evt,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [SYN_W-1:0]  ram_syn,
  input  logic              flash_sb_evt,
  input  logic              flash_nc_evt,
  input  logic [ADDR_W-1:0] flash_addr,
  input  logic [ATTR_W-1:0] flash_attr,
  input  logic [DATA_W-1:0] flash_data,
  output logic              irq_single,
  output logic              irq_ram_nc,
  output logic              irq_flash_nc,
  output logic              irq_noncorr,
  output logic              irq_any
);
  localparam logic [3:0] A_CFG = 4'd0, A_STAT = 4'd1, A_FADDR = 4'd2, A_FATTR = 4'd3,
                         A_FDATA = 4'd4, A_RADDR = 4'd5, A_RSYN = 4'd6, A_RATTR = 4'd7,
                         A_RDATA = 4'd8;
  localparam int RW = 32;

  logic [3:0] en_q, stat_q, win;
  logic [ADDR_W-1:0] fa_q, ra_q;
  logic [ATTR_W-1:0] ft_q, rt_q;
  logic [DATA_W-1:0] fd_q, rd_q;
  logic [SYN_W-1:0]  rs_q;

  wire hit_rsb = ram_sb_evt   & en_q[0];
  wire hit_fsb = flash_sb_evt & en_q[1];
  wire hit_rnc = ram_nc_evt   & en_q[2];
  wire hit_fnc = flash_nc_evt & en_q[3];
  wire wr_cfg  = reg_we && reg_addr == A_CFG;
  wire wr_stat = reg_we && reg_addr == A_STAT;

  always_comb begin
    if (hit_rnc)      win = 4'b0100;
    else if (hit_fnc) win = 4'b1000;
    else if (hit_rsb) win = 4'b0001;
    else if (hit_fsb) win = 4'b0010;
    else              win = 4'b0000;
  end

  wire load_f = win[1] | win[3];
  wire load_r = win[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_cfg) begin
      en_q[0] <= reg_wdata[0];
      en_q[1] <= reg_wdata[1] & (cfg_unlock | en_q[1]);
      en_q[2] <= reg_wdata[2];
      en_q[3] <= reg_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stat_q <= '0;
    else if (win != '0)   stat_q <= win;
    else if (wr_stat)     stat_q <= stat_q & ~reg_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0; ft_q <= '0; fd_q <= '0;
    end else if (load_f) begin
      fa_q <= flash_addr; ft_q <= flash_attr; fd_q <= flash_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0; rt_q <= '0; rd_q <= '0; rs_q <= '0;
    end else if (load_r) begin
      ra_q <= ram_addr; rt_q <= ram_attr; rd_q <= ram_data; rs_q <= ram_syn;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata[3:0] = en_q;
      A_STAT:  reg_rdata[3:0] = stat_q;
      A_FADDR: reg_rdata = RW'(fa_q);
      A_FATTR: reg_rdata = RW'(ft_q);
      A_FDATA: reg_rdata = RW'(fd_q);
      A_RADDR: reg_rdata = RW'(ra_q);
      A_RSYN:  reg_rdata = RW'(rs_q);
      A_RATTR: reg_rdata = RW'(rt_q);
      A_RDATA: reg_rdata = RW'(rd_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_single   = (en_q[0] & stat_q[0]) | (en_q[1] & stat_q[1]);
  assign irq_ram_nc   = en_q[2] & stat_q[2];
  assign irq_flash_nc = en_q[3] & stat_q[3];
  assign irq_noncorr  = irq_ram_nc | irq_flash_nc;
  assign irq_any      = irq_single | irq_noncorr;

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q));

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_rsb | hit_fsb | hit_rnc | hit_fnc) |=> ((stat_q & ~$past(stat_q)) == 4'b0000));

  p_strap_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlock && !en_q[1]) |=> !en_q[1]);

  p_ram_nc_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_nc_evt && en_q[2]) |=> stat_q == 4'b0100);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> stat_q != 4'b0000);

  p_flash_cap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_sb_evt | flash_nc_evt) |=> ($stable(fa_q) && $stable(fd_q)));
endmodule

// File: tb/ecc_err_report_test.sv
module ecc_err_report_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, cfg_unlock = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ram_sb_evt = 0, ram_nc_evt = 0, flash_sb_evt = 0, flash_nc_evt = 0;
  logic [31:0] ram_addr = 0, ram_data = 0, flash_addr = 0, flash_data = 0;
  logic [7:0] ram_attr = 0, ram_syn = 0, flash_attr = 0;
  logic irq_single, irq_ram_nc, irq_flash_nc, irq_noncorr, irq_any;
  int n_chk = 0, n_bad = 0;

  ecc_err_report uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ev(logic rsb, logic rnc, logic fsb, logic fnc,
                    logic [31:0] ra, logic [31:0] fa);
    @(negedge clk);
    ram_sb_evt = rsb; ram_nc_evt = rnc; flash_sb_evt = fsb; flash_nc_evt = fnc;
    ram_addr = ra; ram_data = ~ra; ram_attr = ra[7:0] ^ 8'h5A; ram_syn = ra[15:8];
    flash_addr = fa; flash_data = ~fa; flash_attr = fa[7:0] ^ 8'hA5;
    @(negedge clk);
    ram_sb_evt = 0; ram_nc_evt = 0; flash_sb_evt = 0; flash_nc_evt = 0;
  endtask

  function automatic logic [4:0] irqs();
    return {irq_single, irq_ram_nc, irq_flash_nc, irq_noncorr, irq_any};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 9; a++) begin rd(a[3:0], d); chk("R1 reg zero", d, 0); end
    chk("R1 irqs low", 32'(irqs()), 0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    cfg_unlock = 0; wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 R3 locked write", d, 32'hD);
    cfg_unlock = 1; wr(0, 32'hF); rd(0, d); chk("R2 R3 unlocked write", d, 32'hF);
    cfg_unlock = 0; wr(0, 32'h2); rd(0, d); chk("R3 bit1 held without strap", d, 32'h2);
    wr(0, 32'h0); rd(0, d); chk("R3 clear always allowed", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    ev(1, 1, 1, 1, 32'h1111_2222, 32'h3333_4444);
    rd(1, d); chk("R4 no flag when disabled", d, 0);
    rd(2, d); chk("R4 no flash capture", d, 0);
    rd(5, d); chk("R4 no ram capture", d, 0);
    chk("R4 irqs low", 32'(irqs()), 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    cfg_unlock = 1; wr(0, 32'hF); cfg_unlock = 0;
    ev(1, 0, 0, 0, 32'hAAAA_0001, 0);
    rd(1, d); chk("R5 ram sb flag", d, 32'h1);
    chk("R8 ram sb irqs", 32'(irqs()), 32'b10001);
    rd(5, d); chk("R11 ram sb no capture", d, 0);
    ev(0, 0, 1, 0, 0, 32'hF1A5_0010);
    rd(1, d); chk("R5 flash sb replaces", d, 32'h2);
    chk("R8 flash sb irqs", 32'(irqs()), 32'b10001);
    rd(2, d); chk("R10 flash addr", d, 32'hF1A5_0010);
    rd(3, d); chk("R10 flash attr", d, 32'h10 ^ 32'hA5);
    rd(4, d); chk("R10 flash data", d, ~32'hF1A5_0010);
  endtask

  task automatic t_noncorr();
    logic [31:0] d;
    ev(0, 0, 0, 1, 0, 32'h0BAD_F1A5);
    rd(1, d); chk("R5 flash nc flag", d, 32'h8);
    chk("R9 flash nc irqs", 32'(irqs()), 32'b00111);
    rd(2, d); chk("R10 flash nc addr", d, 32'h0BAD_F1A5);
    ev(0, 1, 0, 0, 32'h1234_5678, 0);
    rd(1, d); chk("R5 ram nc flag", d, 32'h4);
    chk("R9 ram nc irqs", 32'(irqs()), 32'b01011);
    rd(5, d); chk("R11 ram addr", d, 32'h1234_5678);
    rd(6, d); chk("R11 ram syndrome", d, 32'h56);
    rd(7, d); chk("R11 ram attr", d, 32'h78 ^ 32'h5A);
    rd(8, d); chk("R11 ram data", d, ~32'h1234_5678);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    ev(1, 1, 1, 1, 32'h0000_9999, 32'h7777_7777);
    rd(1, d); chk("R6 all four -> ram nc", d, 32'h4);
    rd(2, d); chk("R6 loser flash not captured", d, 32'h0BAD_F1A5);
    ev(1, 0, 0, 1, 32'h5555_5555, 32'h6666_6666);
    rd(1, d); chk("R6 flash nc over ram sb", d, 32'h8);
    rd(2, d); chk("R6 winner flash captured", d, 32'h6666_6666);
    ev(1, 0, 1, 0, 0, 32'h8888_8888);
    rd(1, d); chk("R6 ram sb over flash sb", d, 32'h1);
    rd(2, d); chk("R6 flash sb loser no capture", d, 32'h6666_6666);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    ev(0, 1, 0, 0, 32'h0000_0042, 0);
    wr(1, 32'hFFFF_FFFB); rd(1, d); chk("R7 write 0 keeps flag", d, 32'h4);
    wr(1, 32'h4); rd(1, d); chk("R7 w1c clears", d, 0);
    chk("R7 irqs after clear", 32'(irqs()), 0);
    @(negedge clk); reg_we = 1; reg_addr = 1; reg_wdata = 32'hF; flash_nc_evt = 1;
    @(negedge clk); reg_we = 0; flash_nc_evt = 0;
    rd(1, d); chk("R7 event beats clear", d, 32'h8);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    ev(0, 0, 1, 0, 0, 32'h0000_0123);
    chk("R8 flash sb irq set", 32'(irq_single), 1);
    wr(0, 32'hD); rd(1, d); chk("R8 flag stays", d, 32'h2);
    chk("R8 masked irq", 32'(irqs()), 0);
    rd(0, d); chk("R3 bit1 cleared by write 0", d, 32'hD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_config(); t_disabled(); t_single();
    t_noncorr(); t_priority(); t_clear(); t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule